// File: doc/BRIEF.md
# Memory Dependence Wait-and-Wake Tracker

This block sits beside the issue logic of an out-of-order core and decides when each in-flight memory operation may issue. On insertion it stores the operation's sequence number and whether it is a load or a store. It also stores whether its source registers are already available and which older store, if any, a dependence predictor says it must wait for. The entry waits until both its register condition and its store condition are met. It then becomes ready, and the oldest ready entry is presented at the top output for issue.

Three events drive a waiting entry forward: a register-ready event carrying a sequence number, a store-issue event carrying the issued store's sequence number, and, for operations inserted on the non-speculative path, a release event carrying their sequence number. A squash removes every younger entry. A reported ordering violation is passed on to the predictor's training port one cycle later. Four counters record the inserted loads, the inserted stores, the loads that were predicted to conflict, and the store issues that released at least one waiting entry.

Top module: `mem_dep_tracker`

## Requirements
- R1: After reset, empty is 1, stall is 0, predUpdValid is 0 and all four counters are 0.
- R2: An entry is ready only when its register flag and its store-dependence flag are both set. An insert with predValid=0 starts with the store flag set. A register-ready event (rrValid, rrSeq) sets the register flag of the entry with that sequence number.
- R3: A store-issue event (wakeValid, wakeSeq) sets the store flag of every waiting entry whose predicted store equals wakeSeq.
- R4: topSeq and topIsStore show the ready entry with the oldest sequence number, and popReq removes exactly that entry. Age is wraparound-aware: a is older than b when (a-b) mod 2^SEQ_W has its top bit set. A pop with empty=1 has no effect.
- R5: squashValid removes every entry whose sequence number is younger than squashSeq. In that cycle, insert, pop, register-ready, release and store-issue events are ignored.
- R6: An entry inserted with insNonSpec=1 is not ready until a release event (nsValid, nsSeq) names its sequence number.
- R7: violValid with (violStoreSeq, violLoadSeq) gives predUpdValid=1 and the same pair on predUpdStoreSeq/predUpdLoadSeq one cycle later. Otherwise predUpdValid is 0.
- R8: When all DEPTH slots are occupied, stall is 1 and inserts are refused.
- R9: A register-ready, release or store-issue event in the same cycle as an insert also applies to the inserted entry, if that entry matches the event.
- R10: cntLoads and cntStores count accepted inserts by kind. cntConfLoads counts accepted loads with predValid=1. cntConfStores counts store-issue events that released at least one entry already held in the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| insValid | input | 1 | Insert a new operation |
| insNonSpec | input | 1 | Insert on the non-speculative path |
| insIsStore | input | 1 | Inserted operation is a store |
| insSeq | input | SEQ_W | Sequence number of the inserted operation |
| insRegsReady | input | 1 | Source registers already available |
| predValid | input | 1 | Predictor names a producing store |
| predStoreSeq | input | SEQ_W | Sequence number of the predicted store |
| rrValid | input | 1 | Register-ready event |
| rrSeq | input | SEQ_W | Entry whose registers became ready |
| nsValid | input | 1 | Non-speculative release event |
| nsSeq | input | SEQ_W | Entry released |
| wakeValid | input | 1 | Store-issue event |
| wakeSeq | input | SEQ_W | Sequence number of the issued store |
| popReq | input | 1 | Remove the top entry |
| squashValid | input | 1 | Squash request |
| squashSeq | input | SEQ_W | Entries younger than this are removed |
| violValid | input | 1 | Ordering violation report |
| violStoreSeq | input | SEQ_W | Store of the violation |
| violLoadSeq | input | SEQ_W | Load that ran too early |
| topSeq | output | SEQ_W | Sequence number of the oldest ready entry |
| topIsStore | output | 1 | Oldest ready entry is a store |
| empty | output | 1 | No ready entry |
| stall | output | 1 | Table full |
| predUpdValid | output | 1 | Predictor training request |
| predUpdStoreSeq | output | SEQ_W | Store of the training pair |
| predUpdLoadSeq | output | SEQ_W | Load of the training pair |
| cntLoads | output | CNT_W | Inserted loads |
| cntStores | output | CNT_W | Inserted stores |
| cntConfLoads | output | CNT_W | Loads with a predicted store |
| cntConfStores | output | CNT_W | Store issues that released entries |

## Verification
The assertions check on every cycle that the top entry is never younger than another ready entry, that a pop frees exactly one slot, that a full table never grows, that no entry younger than the squash point survives a squash, and that violation reports are forwarded one cycle later. The bench scenarios cover what no single-cycle property shows. These are the two-condition gating of readiness, the fan-out of one store issue to several waiting loads, holding and releasing on the non-speculative path, events that coincide with an insert, the oldest-first order across sequence-number wraparound, and the counter totals.

// File: rtl/mem_dep_tracker_pkg.sv
package mem_dep_tracker_pkg;
  // Strobes from the control to the datapath; at most one slot changes by insert or pop.
  typedef struct packed {
    logic doSquash;
    logic doInsert;
    logic doPop;
    logic doWake;
    logic doRegs;
    logic doNs;
  } mdtStrobe_t;
endpackage

// File: rtl/mem_dep_tracker_dp.sv
module mem_dep_tracker_dp
  import mem_dep_tracker_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 8,
  parameter int CNT_W  = 16,
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdtStrobe_t        stb,
  input  logic [SLOT_W-1:0] insSlot,
  input  logic [SLOT_W-1:0] popSlot,
  input  logic              insNonSpec,
  input  logic              insIsStore,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic              insRegsReady,
  input  logic              predValid,
  input  logic [SEQ_W-1:0]  predStoreSeq,
  input  logic [SEQ_W-1:0]  rrSeq,
  input  logic [SEQ_W-1:0]  nsSeq,
  input  logic [SEQ_W-1:0]  wakeSeq,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              violValid,
  input  logic [SEQ_W-1:0]  violStoreSeq,
  input  logic [SEQ_W-1:0]  violLoadSeq,
  output logic [DEPTH-1:0]  validVec,
  output logic [DEPTH-1:0]  readyVec,
  output logic [DEPTH-1:0]  storeVec,
  output logic [SEQ_W-1:0]  seqArr [DEPTH],
  output logic              predUpdValid,
  output logic [SEQ_W-1:0]  predUpdStoreSeq,
  output logic [SEQ_W-1:0]  predUpdLoadSeq,
  output logic [CNT_W-1:0]  cntLoads,
  output logic [CNT_W-1:0]  cntStores,
  output logic [CNT_W-1:0]  cntConfLoads,
  output logic [CNT_W-1:0]  cntConfStores
);
  logic             validQ [DEPTH];
  logic             storeQ [DEPTH];
  logic             regsQ  [DEPTH];
  logic             memQ   [DEPTH];
  logic             nsBlkQ [DEPTH];
  logic             depQ   [DEPTH];
  logic [SEQ_W-1:0] seqQ   [DEPTH];
  logic [SEQ_W-1:0] depSeqQ[DEPTH];
  logic [DEPTH-1:0] wokeVec;

  // Initial flags of an inserted entry, including events landing in the same cycle.
  logic insRegs, insMem, insNsBlk;
  assign insRegs  = insRegsReady | (stb.doRegs && rrSeq == insSeq);
  assign insMem   = ~predValid | (stb.doWake && wakeSeq == predStoreSeq);
  assign insNsBlk = insNonSpec & ~(stb.doNs && nsSeq == insSeq);

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic [SEQ_W-1:0] sqDiff;
    logic killSq, rrHit, nsHit, wakeHit, isIns, isPop;
    assign sqDiff  = squashSeq - seqQ[i];
    assign killSq  = sqDiff[SEQ_W-1];
    assign rrHit   = stb.doRegs && rrSeq == seqQ[i];
    assign nsHit   = stb.doNs && nsSeq == seqQ[i];
    assign wakeHit = stb.doWake && depQ[i] && depSeqQ[i] == wakeSeq;
    assign isIns   = stb.doInsert && insSlot == SLOT_W'(i);
    assign isPop   = stb.doPop && popSlot == SLOT_W'(i);
    assign wokeVec[i] = validQ[i] && wakeHit && !memQ[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[i]  <= 1'b0;
        storeQ[i]  <= 1'b0;
        regsQ[i]   <= 1'b0;
        memQ[i]    <= 1'b0;
        nsBlkQ[i]  <= 1'b0;
        depQ[i]    <= 1'b0;
        seqQ[i]    <= '0;
        depSeqQ[i] <= '0;
      end else if (stb.doSquash) begin
        if (killSq) validQ[i] <= 1'b0;
      end else if (isPop) begin
        validQ[i] <= 1'b0;
      end else if (isIns) begin
        validQ[i]  <= 1'b1;
        storeQ[i]  <= insIsStore;
        regsQ[i]   <= insRegs;
        memQ[i]    <= insMem;
        nsBlkQ[i]  <= insNsBlk;
        depQ[i]    <= predValid;
        seqQ[i]    <= insSeq;
        depSeqQ[i] <= predStoreSeq;
      end else if (validQ[i]) begin
        if (rrHit)   regsQ[i]  <= 1'b1;
        if (wakeHit) memQ[i]   <= 1'b1;
        if (nsHit)   nsBlkQ[i] <= 1'b0;
      end
    end

    assign validVec[i] = validQ[i];
    assign readyVec[i] = validQ[i] && regsQ[i] && memQ[i] && !nsBlkQ[i];
    assign storeVec[i] = storeQ[i];
    assign seqArr[i]   = seqQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLoads      <= '0;
      cntStores     <= '0;
      cntConfLoads  <= '0;
      cntConfStores <= '0;
    end else begin
      if (stb.doInsert) begin
        if (insIsStore) cntStores <= cntStores + CNT_W'(1);
        else            cntLoads  <= cntLoads + CNT_W'(1);
        if (!insIsStore && predValid) cntConfLoads <= cntConfLoads + CNT_W'(1);
      end
      if (stb.doWake && |wokeVec) cntConfStores <= cntConfStores + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predUpdValid    <= 1'b0;
      predUpdStoreSeq <= '0;
      predUpdLoadSeq  <= '0;
    end else begin
      predUpdValid <= violValid;
      if (violValid) begin
        predUpdStoreSeq <= violStoreSeq;
        predUpdLoadSeq  <= violLoadSeq;
      end
    end
  end
endmodule

// File: rtl/mem_dep_tracker_ctrl.sv
module mem_dep_tracker_ctrl
  import mem_dep_tracker_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 8,
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              insValid,
  input  logic              popReq,
  input  logic              squashValid,
  input  logic              wakeValid,
  input  logic              rrValid,
  input  logic              nsValid,
  input  logic [DEPTH-1:0]  validVec,
  input  logic [DEPTH-1:0]  readyVec,
  input  logic [SEQ_W-1:0]  seqArr [DEPTH],
  output mdtStrobe_t        stb,
  output logic [SLOT_W-1:0] insSlot,
  output logic [SLOT_W-1:0] popSlot,
  output logic              full,
  output logic              empty
);
  assign full  = &validVec;
  assign empty = ~|readyVec;

  // Lowest free slot takes the next insert.
  always_comb begin
    insSlot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!validVec[i]) insSlot = SLOT_W'(i);
  end

  // Oldest ready slot: no other ready slot is older under wraparound age.
  always_comb begin
    logic [SEQ_W-1:0] d;
    logic isMin, found;
    popSlot = '0;
    found   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      isMin = readyVec[i];
      for (int j = 0; j < DEPTH; j++) begin
        d = seqArr[j] - seqArr[i];
        if (j != i && readyVec[j] && d[SEQ_W-1]) isMin = 1'b0;
      end
      if (isMin && !found) begin
        popSlot = SLOT_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    stb.doSquash = squashValid;
    stb.doInsert = insValid && !full && !squashValid;
    stb.doPop    = popReq && !empty && !squashValid;
    stb.doWake   = wakeValid && !squashValid;
    stb.doRegs   = rrValid && !squashValid;
    stb.doNs     = nsValid && !squashValid;
  end
endmodule

// File: rtl/mem_dep_tracker.sv
module mem_dep_tracker
  import mem_dep_tracker_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             insNonSpec,
  input  logic             insIsStore,
  input  logic [SEQ_W-1:0] insSeq,
  input  logic             insRegsReady,
  input  logic             predValid,
  input  logic [SEQ_W-1:0] predStoreSeq,
  input  logic             rrValid,
  input  logic [SEQ_W-1:0] rrSeq,
  input  logic             nsValid,
  input  logic [SEQ_W-1:0] nsSeq,
  input  logic             wakeValid,
  input  logic [SEQ_W-1:0] wakeSeq,
  input  logic             popReq,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             violValid,
  input  logic [SEQ_W-1:0] violStoreSeq,
  input  logic [SEQ_W-1:0] violLoadSeq,
  output logic [SEQ_W-1:0] topSeq,
  output logic             topIsStore,
  output logic             empty,
  output logic             stall,
  output logic             predUpdValid,
  output logic [SEQ_W-1:0] predUpdStoreSeq,
  output logic [SEQ_W-1:0] predUpdLoadSeq,
  output logic [CNT_W-1:0] cntLoads,
  output logic [CNT_W-1:0] cntStores,
  output logic [CNT_W-1:0] cntConfLoads,
  output logic [CNT_W-1:0] cntConfStores
);
  localparam int SLOT_W = $clog2(DEPTH);

  mdtStrobe_t        stb;
  logic [SLOT_W-1:0] insSlot, popSlot;
  logic [DEPTH-1:0]  validVec, readyVec, storeVec;
  logic [SEQ_W-1:0]  seqArr [DEPTH];

  mem_dep_tracker_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SLOT_W(SLOT_W)) u_ctrl (
    .insValid(insValid), .popReq(popReq), .squashValid(squashValid),
    .wakeValid(wakeValid), .rrValid(rrValid), .nsValid(nsValid),
    .validVec(validVec), .readyVec(readyVec), .seqArr(seqArr),
    .stb(stb), .insSlot(insSlot), .popSlot(popSlot), .full(stall), .empty(empty)
  );

  mem_dep_tracker_dp #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .insSlot(insSlot), .popSlot(popSlot),
    .insNonSpec(insNonSpec), .insIsStore(insIsStore), .insSeq(insSeq),
    .insRegsReady(insRegsReady), .predValid(predValid), .predStoreSeq(predStoreSeq),
    .rrSeq(rrSeq), .nsSeq(nsSeq), .wakeSeq(wakeSeq), .squashSeq(squashSeq),
    .violValid(violValid), .violStoreSeq(violStoreSeq), .violLoadSeq(violLoadSeq),
    .validVec(validVec), .readyVec(readyVec), .storeVec(storeVec), .seqArr(seqArr),
    .predUpdValid(predUpdValid), .predUpdStoreSeq(predUpdStoreSeq),
    .predUpdLoadSeq(predUpdLoadSeq), .cntLoads(cntLoads), .cntStores(cntStores),
    .cntConfLoads(cntConfLoads), .cntConfStores(cntConfStores)
  );

  assign topSeq     = seqArr[popSlot];
  assign topIsStore = storeVec[popSlot];
endmodule

// File: rtl/mem_dep_tracker_chk.sv
module mem_dep_tracker_chk #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             insValid,
  input logic             popReq,
  input logic             squashValid,
  input logic [SEQ_W-1:0] squashSeq,
  input logic             violValid,
  input logic [SEQ_W-1:0] violStoreSeq,
  input logic [SEQ_W-1:0] violLoadSeq,
  input logic             predUpdValid,
  input logic [SEQ_W-1:0] predUpdStoreSeq,
  input logic [SEQ_W-1:0] predUpdLoadSeq,
  input logic             empty,
  input logic             stall,
  input logic [SEQ_W-1:0] topSeq,
  input logic [DEPTH-1:0] validVec,
  input logic [DEPTH-1:0] readyVec,
  input logic [SEQ_W-1:0] seqArr [DEPTH]
);
  logic [SEQ_W-1:0] sqSeqQ;
  logic youngerLive, olderReady;

  always_ff @(posedge clk) sqSeqQ <= squashSeq;

  always_comb begin
    logic [SEQ_W-1:0] d;
    youngerLive = 1'b0;
    olderReady  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      d = sqSeqQ - seqArr[i];
      if (validVec[i] && d[SEQ_W-1]) youngerLive = 1'b1;
      d = seqArr[i] - topSeq;
      if (readyVec[i] && d[SEQ_W-1]) olderReady = 1'b1;
    end
  end

  AST_TOP_OLDEST: assert property (@(posedge clk) disable iff (!rstN)
    !empty |-> !olderReady); // R4
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !empty && !squashValid && !insValid)
    |=> $countones(validVec) == $past($countones(validVec)) - 1); // R4
  AST_SQUASH_GONE: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |=> !youngerLive); // R5
  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $countones(validVec) <= $past($countones(validVec))); // R8
  AST_VIOL_FWD: assert property (@(posedge clk) disable iff (!rstN)
    violValid |=> predUpdValid && predUpdStoreSeq == $past(violStoreSeq)
                  && predUpdLoadSeq == $past(violLoadSeq)); // R7
  AST_VIOL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !violValid |=> !predUpdValid); // R7
endmodule

bind mem_dep_tracker mem_dep_tracker_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rstN(rstN), .insValid(insValid), .popReq(popReq),
  .squashValid(squashValid), .squashSeq(squashSeq), .violValid(violValid),
  .violStoreSeq(violStoreSeq), .violLoadSeq(violLoadSeq),
  .predUpdValid(predUpdValid), .predUpdStoreSeq(predUpdStoreSeq),
  .predUpdLoadSeq(predUpdLoadSeq), .empty(empty), .stall(stall), .topSeq(topSeq),
  .validVec(validVec), .readyVec(readyVec), .seqArr(seqArr)
);

// File: tb/mem_dep_tracker_bench.sv
module mem_dep_tracker_bench;
  localparam int SEQ_W = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insValid = 0, insNonSpec = 0, insIsStore = 0, insRegsReady = 0, predValid = 0;
  logic [SEQ_W-1:0] insSeq = '0, predStoreSeq = '0;
  logic rrValid = 0, nsValid = 0, wakeValid = 0, popReq = 0, squashValid = 0, violValid = 0;
  logic [SEQ_W-1:0] rrSeq = '0, nsSeq = '0, wakeSeq = '0, squashSeq = '0;
  logic [SEQ_W-1:0] violStoreSeq = '0, violLoadSeq = '0;
  logic [SEQ_W-1:0] topSeq, predUpdStoreSeq, predUpdLoadSeq;
  logic topIsStore, empty, stall, predUpdValid;
  logic [CNT_W-1:0] cntLoads, cntStores, cntConfLoads, cntConfStores;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  int expQ[$];
  string expTag[$];

  always #5 clk = ~clk;

  mem_dep_tracker u_mem_dep_tracker (.*);

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic insert(int seq, bit isSt, bit regs, bit pv, int pSeq, bit nonSpec);
    insValid = 1; insSeq = SEQ_W'(seq); insIsStore = isSt; insRegsReady = regs;
    predValid = pv; predStoreSeq = SEQ_W'(pSeq); insNonSpec = nonSpec;
    tick();
    insValid = 0; predValid = 0; insNonSpec = 0; insIsStore = 0; insRegsReady = 0;
  endtask

  // Driver: queue the expected top entry, then request the pop.
  task automatic popExpect(int seq, string req);
    expQ.push_back(seq);
    expTag.push_back(req);
    popReq = 1;
    tick();
    popReq = 0;
  endtask

  // Monitor: on every accepted pop, compare the presented entry with the queue.
  always @(negedge clk) begin
    if (rstN && popReq && !squashValid) begin
      if (empty) begin
        if (expQ.size() != 0) begin
          check(expTag[0], 1, 0);
          void'(expQ.pop_front());
          void'(expTag.pop_front());
        end
      end else if (expQ.size() == 0) begin
        check("R4 unexpected pop", 1, 0);
      end else begin
        check(expTag[0], int'(topSeq), expQ[0]);
        void'(expQ.pop_front());
        void'(expTag.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 5000);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 empty", int'(empty), 1);
    check("R1 stall", int'(stall), 0);
    check("R1 predUpdValid", int'(predUpdValid), 0);
    check("R1 cntLoads", int'(cntLoads), 0);
    check("R1 cntConfStores", int'(cntConfStores), 0);
    rstN = 1;
    tick();

    // R2: registers ready, no predicted store -> ready at once
    insert(10, 0, 1, 0, 0, 0);
    check("R2 ready entry", int'(empty), 0);
    check("R2 top", int'(topSeq), 10);
    insert(11, 0, 0, 0, 0, 0);
    check("R2 waiting on registers keeps top", int'(topSeq), 10);
    popExpect(10, "R4 pop 10");
    check("R2 no ready without register flag", int'(empty), 1);
    rrValid = 1; rrSeq = 11; tick(); rrValid = 0;
    check("R2 register event makes ready", int'(empty), 0);
    popExpect(11, "R4 pop 11");
    check("R4 empty after pops", int'(empty), 1);

    // R3: one store wakes two dependents
    insert(20, 1, 1, 0, 0, 0);
    insert(21, 0, 1, 1, 20, 0);
    insert(22, 0, 1, 1, 20, 0);
    check("R3 store at top", int'(topSeq), 20);
    check("R3 topIsStore", int'(topIsStore), 1);
    popExpect(20, "R4 pop store 20");
    check("R2 dependents blocked before wake", int'(empty), 1);
    wakeValid = 1; wakeSeq = 20; tick(); wakeValid = 0;
    check("R3 wake releases", int'(empty), 0);
    popExpect(21, "R3 pop 21");
    popExpect(22, "R3 pop 22");
    check("R3 both released", int'(empty), 1);

    // R4: wraparound age order (252 older than 3)
    insert(250, 0, 0, 0, 0, 0);
    insert(3, 0, 1, 0, 0, 0);
    insert(252, 0, 1, 0, 0, 0);
    check("R4 wrap oldest", int'(topSeq), 252);
    rrValid = 1; rrSeq = 250; tick(); rrValid = 0;
    check("R4 older now ready", int'(topSeq), 250);
    popExpect(250, "R4 pop 250");
    popExpect(252, "R4 pop 252");
    popExpect(3, "R4 pop 3");

    // R6: non-speculative hold and release
    insert(40, 0, 1, 0, 0, 1);
    check("R6 held", int'(empty), 1);
    nsValid = 1; nsSeq = 40; tick(); nsValid = 0;
    check("R6 released", int'(empty), 0);
    popExpect(40, "R6 pop 40");

    // R9: register and store events coincide with insert
    insValid = 1; insSeq = 51; insRegsReady = 0; predValid = 1; predStoreSeq = 50;
    rrValid = 1; rrSeq = 51; wakeValid = 1; wakeSeq = 50;
    tick();
    insValid = 0; predValid = 0; rrValid = 0; wakeValid = 0;
    check("R9 same-cycle events", int'(empty), 0);
    popExpect(51, "R9 pop 51");

    // R5: squash beats insert and pop in the same cycle
    insert(60, 0, 1, 0, 0, 0);
    insert(61, 0, 1, 0, 0, 0);
    insert(62, 0, 1, 0, 0, 0);
    insert(63, 0, 1, 0, 0, 0);
    squashValid = 1; squashSeq = 61; popReq = 1;
    insValid = 1; insSeq = 64; insRegsReady = 1;
    tick();
    squashValid = 0; popReq = 0; insValid = 0; insRegsReady = 0;
    check("R5 pop suppressed", int'(topSeq), 60);
    popExpect(60, "R5 pop 60");
    popExpect(61, "R5 pop 61");
    check("R5 younger removed", int'(empty), 1);

    // R8: fill the table, refused insert, then squash all
    for (int k = 0; k < 16; k++) insert(100 + k, 0, 0, 0, 0, 0);
    check("R8 stall when full", int'(stall), 1);
    insert(116, 0, 1, 0, 0, 0);
    check("R8 insert refused", int'(empty), 1);
    check("R10 refused insert not counted", int'(cntLoads), 29);
    squashValid = 1; squashSeq = 99; tick(); squashValid = 0;
    check("R5 squash all", int'(stall), 0);
    popReq = 1; tick(); popReq = 0;
    check("R4 pop on empty ignored", int'(empty), 1);

    // R7: violation forwarding
    violValid = 1; violStoreSeq = 7; violLoadSeq = 9; tick(); violValid = 0;
    check("R7 forward valid", int'(predUpdValid), 1);
    check("R7 forward store", int'(predUpdStoreSeq), 7);
    check("R7 forward load", int'(predUpdLoadSeq), 9);
    tick();
    check("R7 one-shot", int'(predUpdValid), 0);

    // R10: counter totals
    check("R10 cntLoads", int'(cntLoads), 29);
    check("R10 cntStores", int'(cntStores), 1);
    check("R10 cntConfLoads", int'(cntConfLoads), 3);
    check("R10 cntConfStores", int'(cntConfStores), 1);
    check("R4 scoreboard drained", expQ.size(), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule